// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scanner

This block time-multiplexes three fluorescent display panels. Each panel has 40 digits and 16 segments per digit. Every panel has one grid line per digit. The 16 segment (anode) lines of a panel are bussed across all of its digits. A single scan sequence drives the grid lines, and all three panels share it: one digit index is lit at a time, in ascending order, and the index wraps back to the first digit after the last one. Because a panel's segment lines are common to all of its digits, the segment pattern for the next digit must be loaded while every grid is dark.

The scan repeats one cycle pattern per digit. First comes a blanking interval of `BLANK` clock cycles with all grids off. On the last cycle of that interval, the three 16-bit segment patterns for the coming digit are read from an internal pattern memory and latched. The grid for that digit is then lit for `DWELL` cycles.

A host fills the pattern memory through a valid/ready write port carrying a panel index, a digit index and a 16-bit pattern. Back-pressure rule: a write is taken on a rising edge where both `wr_valid_i` and `wr_ready_o` are high. The host must hold the write stable while `wr_ready_o` is low. `wr_ready_o` drops for exactly one cycle per digit, the cycle in which the memory is read for latching. So a write never shares a cycle with a latch read and can never alter a pattern already on the outputs.

Top module: `vfd_scanner`

## Requirements
- R1: While reset is asserted and after it is released, `grid_o`, `anode_o` and `frame_start_o` are all zero, and every pattern memory entry reads as zero until the host writes it.
- R2: Counting rising edges from reset release, grids stay dark for the first `BLANK` edges. Digit k (k = 0..39, then repeating from 0) is lit from edge `BLANK + n*(DWELL+BLANK)` for `DWELL` edges, where n counts digit slots since reset. Grids are then dark for `BLANK` edges.
- R3: `grid_o` is either all zero or has exactly one bit set. Bit k is the grid of digit k, and the same bit drives the like-numbered digit of all three panels.
- R4: While digit k is lit, `anode_o[16*p+15:16*p]` equals the pattern stored for panel p, digit k, at the edge that lit it. Bit 0 of each 16-bit slice is the underline segment.
- R5: `anode_o` changes only on the edge that lights a grid. A write to the digit currently lit leaves the outputs unchanged until that digit is next scanned.
- R6: `frame_start_o` is high for exactly the first lit cycle of digit 0. Consecutive pulses are `40*(DWELL+BLANK)` cycles apart.
- R7: A write is accepted on a rising edge where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` is low only in the cycle before a grid lights, and a write presented then waits.
- R8: An accepted write whose panel index is 3 or whose digit index is 40 or more changes no pattern memory entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Host write request |
| wr_ready_o | output | 1 | Write can be accepted this cycle |
| wr_panel_i | input | 2 | Panel index of the write, 0..2 |
| wr_digit_i | input | 6 | Digit index of the write, 0..39 |
| wr_data_i | input | 16 | Segment pattern, bit 0 = underline |
| grid_o | output | 40 | One-hot grid enables, shared by the panels |
| anode_o | output | 48 | Latched segment lines, panel p in bits 16p+15..16p |
| frame_start_o | output | 1 | Pulse on the first lit cycle of digit 0 |

## Verification
The grid and all three anode slices change on the rising edge that ends a blanking interval, one register after the memory read, and the next falling edge shows them. A write accepted on an edge is stored on that edge and shows up at the next latch edge of its digit, never earlier. `wr_ready_o` is combinational from the scan state, so it is valid at the falling edge before the latch edge. The bench keeps its own count of edges since reset and derives from it, at each falling edge, the expected grid, ready and frame values. It queues the expected segment word one half-cycle before each latch edge, from a pattern model that is updated only on the edge where a write is accepted.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef enum logic {
    PH_BLANK = 1'b0,
    PH_DWELL = 1'b1
  } scan_phase_e;

  function automatic int unsigned idx_width(input int unsigned count);
    return (count <= 1) ? 1 : $clog2(count);
  endfunction

endpackage

// File: rtl/vfd_pattern_ram.sv
module vfd_pattern_ram
  import vfd_scan_pkg::*;
#(
  parameter int PANELS = 3,
  parameter int DIGITS = 40,
  parameter int SEGS   = 16,
  parameter int PW     = idx_width(PANELS),
  parameter int DW     = idx_width(DIGITS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PW-1:0]            wpanel_i,
  input  logic [DW-1:0]            wdigit_i,
  input  logic [SEGS-1:0]          wdata_i,
  input  logic [DW-1:0]            rdigit_i,
  output logic [PANELS*SEGS-1:0]   rdata_o
);

  logic [SEGS-1:0] mem_q [PANELS][DIGITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PANELS; p++) begin
        for (int d = 0; d < DIGITS; d++) begin
          mem_q[p][d] <= '0;
        end
      end
    end else if (we_i) begin
      mem_q[wpanel_i][wdigit_i] <= wdata_i;
    end
  end

  // One whole digit column is read across every panel at once.
  for (genvar gp = 0; gp < PANELS; gp++) begin : g_rd
    assign rdata_o[gp*SEGS +: SEGS] = mem_q[gp][rdigit_i];
  end

endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int DIGITS = 40,
  parameter int DWELL  = 250,
  parameter int BLANK  = 4,
  parameter int DW     = idx_width(DIGITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DW-1:0]     digit_o,
  output logic              load_o,
  output logic [DIGITS-1:0] grid_o,
  output logic              frame_o
);

  localparam int CMAX = (DWELL > BLANK) ? DWELL : BLANK;
  localparam int CW   = idx_width(CMAX);
  localparam logic [CW-1:0] DWELL_END = CW'(DWELL - 1);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK - 1);
  localparam logic [DW-1:0] LAST_DIG  = DW'(DIGITS - 1);

  scan_phase_e       phase_q;
  logic [CW-1:0]     cnt_q;
  logic [DW-1:0]     digit_q;
  logic [DIGITS-1:0] grid_dec;

  assign digit_o = digit_q;
  assign load_o  = (phase_q == PH_BLANK) && (cnt_q == BLANK_END);

  always_comb begin
    grid_dec          = '0;
    grid_dec[digit_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_BLANK;
      cnt_q   <= '0;
      digit_q <= '0;
      grid_o  <= '0;
      frame_o <= 1'b0;
    end else begin
      frame_o <= 1'b0;
      if (phase_q == PH_BLANK) begin
        if (cnt_q == BLANK_END) begin
          phase_q <= PH_DWELL;
          cnt_q   <= '0;
          grid_o  <= grid_dec;
          frame_o <= (digit_q == '0);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == DWELL_END) begin
          phase_q <= PH_BLANK;
          cnt_q   <= '0;
          grid_o  <= '0;
          digit_q <= (digit_q == LAST_DIG) ? '0 : digit_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  grid_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grid_o));

  // R3
  grid_switch_via_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grid_o != '0) |=> (grid_o == $past(grid_o)) || (grid_o == '0));

  // R6
  frame_on_digit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> grid_o[0]);

  // R2
  dwell_count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DWELL) |-> (cnt_q <= DWELL_END));

  // R2
  blank_count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BLANK) |-> (cnt_q <= BLANK_END));

endmodule

// File: rtl/vfd_anode_latch.sv
module vfd_anode_latch #(
  parameter int SEGS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SEGS-1:0] d_i,
  output logic [SEGS-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/vfd_scanner.sv
module vfd_scanner
  import vfd_scan_pkg::*;
#(
  parameter int PANELS = 3,
  parameter int DIGITS = 40,
  parameter int SEGS   = 16,
  parameter int DWELL  = 250,
  parameter int BLANK  = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_valid_i,
  output logic                             wr_ready_o,
  input  logic [idx_width(PANELS)-1:0]     wr_panel_i,
  input  logic [idx_width(DIGITS)-1:0]     wr_digit_i,
  input  logic [SEGS-1:0]                  wr_data_i,
  output logic [DIGITS-1:0]                grid_o,
  output logic [PANELS*SEGS-1:0]           anode_o,
  output logic                             frame_start_o
);

  localparam int PW = idx_width(PANELS);
  localparam int DW = idx_width(DIGITS);

  logic [DW-1:0]          scan_digit;
  logic                   latch_now;
  logic                   in_range;
  logic                   wr_en;
  logic [PANELS*SEGS-1:0] col_data;

  assign in_range   = (int'(wr_panel_i) < PANELS) && (int'(wr_digit_i) < DIGITS);
  assign wr_ready_o = ~latch_now;
  assign wr_en      = wr_valid_i & wr_ready_o & in_range;

  vfd_scan_timer #(
    .DIGITS (DIGITS),
    .DWELL  (DWELL),
    .BLANK  (BLANK),
    .DW     (DW)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .digit_o (scan_digit),
    .load_o  (latch_now),
    .grid_o  (grid_o),
    .frame_o (frame_start_o)
  );

  vfd_pattern_ram #(
    .PANELS (PANELS),
    .DIGITS (DIGITS),
    .SEGS   (SEGS),
    .PW     (PW),
    .DW     (DW)
  ) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .wpanel_i (wr_panel_i),
    .wdigit_i (wr_digit_i),
    .wdata_i  (wr_data_i),
    .rdigit_i (scan_digit),
    .rdata_o  (col_data)
  );

  for (genvar gp = 0; gp < PANELS; gp++) begin : g_panel
    vfd_anode_latch #(
      .SEGS (SEGS)
    ) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (latch_now),
      .d_i    (col_data[gp*SEGS +: SEGS]),
      .q_o    (anode_o[gp*SEGS +: SEGS])
    );
  end

  // R5
  anode_hold_while_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grid_o != '0) && ($past(grid_o) != '0)) |-> $stable(anode_o));

  // R7
  ready_low_then_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> (grid_o != '0));

  // R7
  ready_low_only_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |-> (grid_o == '0));

endmodule

// File: tb/tb_vfd_scanner.sv
`timescale 1ns/1ps
module tb_vfd_scanner;

  localparam int NP = 3;
  localparam int ND = 40;
  localparam int NS = 16;
  localparam int D  = 4;
  localparam int B  = 2;
  localparam int P  = D + B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [1:0]    wr_panel = '0;
  logic [5:0]    wr_digit = '0;
  logic [15:0]   wr_data = '0;
  logic [39:0]   grid;
  logic [47:0]   anode;
  logic          frame_start;

  int  errs = 0;
  int  checks = 0;
  int  cyc = 0;
  bit  running = 0;
  bit  done = 0;
  int  last_frame = -1;
  logic [15:0] model [NP][ND];
  logic [47:0] exp_q [$];
  logic [47:0] cur_exp = '0;

  always #2.5 clk = ~clk;

  vfd_scanner #(.PANELS(NP), .DIGITS(ND), .SEGS(NS), .DWELL(D), .BLANK(B)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_panel_i(wr_panel), .wr_digit_i(wr_digit), .wr_data_i(wr_data),
    .grid_o(grid), .anode_o(anode), .frame_start_o(frame_start));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // Driver: presents a write, waits on ready, updates the model on the accepting edge.
  task automatic host_write(input int p, input int d, input logic [15:0] v);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_panel = p[1:0];
    wr_digit = d[5:0];
    wr_data  = v;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    if (p < NP && d < ND) model[p][d] = v;
    #1 wr_valid = 1'b0;
  endtask

  always @(posedge clk) if (running) cyc++;

  // Monitor (compare) then predictor (push expected item for the coming latch edge).
  always @(negedge clk) begin
    if (!running) begin
      if (!rst_n) begin
        chk("R1 grid in reset", 64'(grid), 64'd0);
        chk("R1 anode in reset", 64'(anode), 64'd0);
        chk("R1 frame in reset", 64'(frame_start), 64'd0);
      end
    end else if (!done) begin
      int t, k, dig, nxt;
      bit on;
      logic [39:0] eg;
      on = 0; t = 0; dig = 0;
      if (cyc >= B) begin
        t = (cyc - B) % P;
        k = (cyc - B) / P;
        on = (t < D);
        dig = k % ND;
      end
      eg = on ? (40'd1 << dig) : 40'd0;
      chk("R2/R3 grid", 64'(grid), 64'(eg));
      chk("R6 frame_start", 64'(frame_start), 64'(on && t == 0 && dig == 0));
      if (on && t == 0) begin
        if (exp_q.size() == 0) begin
          checks++; errs++;
          $display("FAIL R4 at cycle %0d: actual=activation expected=queued item", cyc);
        end else begin
          cur_exp = exp_q.pop_front();
          chk("R4 anode latched", 64'(anode), 64'(cur_exp));
        end
        if (dig == 0) begin
          if (last_frame >= 0) chk("R6 frame period", 64'(cyc - last_frame), 64'(ND * P));
          last_frame = cyc;
        end
      end else if (on) begin
        chk("R5 anode held", 64'(anode), 64'(cur_exp));
      end
      nxt = cyc + 1;
      chk("R7 ready", 64'(wr_ready), 64'(!((nxt >= B) && ((nxt - B) % P == 0))));
      if ((nxt >= B) && ((nxt - B) % P == 0)) begin
        int dn;
        dn = ((nxt - B) / P) % ND;
        exp_q.push_back({model[2][dn], model[1][dn], model[0][dn]});
      end
    end
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int d = 0; d < ND; d++) model[p][d] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1: early digits still show the cleared memory while writes fill from the top.
    for (int d = ND - 1; d >= 0; d--)
      for (int p = 0; p < NP; p++)
        host_write(p, d, 16'((p * 4099 + d * 257 + 17) ^ (d << 9)));
    repeat (2 * ND * P) @(posedge clk);
    // R5: rewrite the digit that is lit right now.
    do @(negedge clk); while (!grid[5]);
    host_write(1, 5, 16'hA5C3);
    host_write(0, 0, 16'h0001);  // R4: underline only on digit 0, panel 0
    // R8: out-of-range writes change nothing.
    host_write(3, 7, 16'hFFFF);
    host_write(0, 40, 16'hFFFF);
    host_write(2, 63, 16'hFFFF);
    repeat (2 * ND * P) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule